// File: doc/BRIEF.md
# Endpoint FIFO Segment Allocator

This block manages a shared pool of endpoint FIFO memory. The pool is divided into fixed 512-byte units, and an internal 128-bit occupancy map records which units are taken. A controller asks it to place an endpoint's buffer by giving the endpoint's maximum packet size and its slot count. The block sizes the buffer, searches the map from the lowest unit upward for the first run of free units that is long enough, claims that run, and returns the byte address and the byte size of the buffer.

A release request gives back an address and a size. The block clears the units that cover that range and leaves every other unit alone. Each request ends with a one-cycle completion pulse. A chip that keeps separate pools for transmit and receive places one instance per pool, each with its own base address.

Top module: `fifo_seg_alloc`

## Requirements
- R1: On an allocate request (`req_op_i` = 0) the segment size is `req_maxp_i` rounded up to the next power of two. A value that is already a power of two is kept, and 0 is treated as 1.
- R2: The returned `rsp_size_o` on a successful allocate is (`req_slot_i` + 1) times the segment size, in bytes.
- R3: The number of units claimed is the byte size divided by 512, rounded up, and never less than one.
- R4: Placement is first-fit. The claimed run starts at the lowest unit index that begins a run of enough free units. `rsp_addr_o` equals `BASE_ADDR` + index × 512, and the claimed units are then in use.
- R5: If no run of free units is long enough, including any request that needs more than 128 units, `fail_o` is raised together with `done_o` and the occupancy map is left unchanged.
- R6: A release request (`req_op_i` = 1) frees exactly the units from (`req_addr_i` − `BASE_ADDR`)/512 onward, for ceil(`req_size_i`/512) units (at least one). Units outside that range keep their state.
- R7: `done_o` is high for exactly one cycle per request. A release completes in the cycle after it is accepted, and an allocate completes within 129 cycles of acceptance.
- R8: While `busy_o` is high, `req_valid_i` is ignored and the pending request and the map are unaffected.
- R9: After reset all units are free and `busy_o`, `done_o` and `fail_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, sampled when not busy |
| req_op_i | input | 1 | 0 = allocate, 1 = release |
| req_maxp_i | input | MAXP_W | Endpoint maximum packet size in bytes (allocate) |
| req_slot_i | input | SLOT_W | Extra slot count; buffer holds slot+1 segments (allocate) |
| req_addr_i | input | ADDR_W | Byte address of the region to release |
| req_size_i | input | SIZE_W | Byte size of the region to release |
| busy_o | output | 1 | An allocate search is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Allocate found no space (valid with done_o) |
| rsp_addr_o | output | ADDR_W | Byte address of the claimed buffer |
| rsp_size_o | output | SIZE_W | Byte size of the claimed buffer |

## Verification
The hardest situation to reach is a first-fit decision that passes over a hole that is too short, while the units beyond it were claimed and released in between. The bench builds this from the ports. It claims three neighbouring buffers and releases the middle one. A one-unit request refills the hole, which shows the release cleared only its own unit. The bench then releases the lowest buffer, leaving a two-unit hole. A three-unit request must skip that hole, and a two-unit request must then fill it exactly. A request sent during a long search, aimed at a unit known to be taken, checks that busy requests are dropped.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
    typedef enum logic { OP_ALLOC = 1'b0, OP_FREE = 1'b1 } fsa_op_e;
    typedef enum logic { ST_IDLE = 1'b0, ST_SCAN = 1'b1 } fsa_state_e;
endpackage

// File: rtl/fsa_sizer.sv
module fsa_sizer #(
    parameter int MAXP_W     = 16,
    parameter int SLOT_W     = 2,
    parameter int UNIT_BYTES = 512,
    localparam int SEG_W  = MAXP_W + 1,
    localparam int SIZE_W = SEG_W + SLOT_W,
    localparam int UB     = $clog2(UNIT_BYTES),
    localparam int CNT_W  = SIZE_W - UB + 1
) (
    input  logic [MAXP_W-1:0] maxp_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [SIZE_W-1:0] bytes_o,
    output logic [CNT_W-1:0]  units_o
);
    logic [SEG_W-1:0]  seg;
    logic [SLOT_W:0]   slot_p1;
    logic [SIZE_W:0]   rounded;

    always_comb begin
        seg = SEG_W'(1);
        for (int i = 0; i < MAXP_W; i++) begin
            if ((SEG_W'(1) << i) < {1'b0, maxp_i}) seg = SEG_W'(1) << (i + 1);
        end
        slot_p1 = {1'b0, slot_i} + 1'b1;
        bytes_o = SIZE_W'(seg) * SIZE_W'(slot_p1);
        rounded = ({1'b0, bytes_o} + (SIZE_W + 1)'(UNIT_BYTES - 1)) >> UB;
        units_o = CNT_W'(rounded);
        if (units_o == '0) units_o = CNT_W'(1);
    end
endmodule

// File: rtl/fsa_rangemask.sv
module fsa_rangemask #(
    parameter int NUM_UNITS = 128,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 11
) (
    input  logic [ADDR_W-1:0]    first_i,
    input  logic [CNT_W-1:0]     count_i,
    output logic [NUM_UNITS-1:0] mask_o
);
    logic [ADDR_W:0] last_excl;
    assign last_excl = {1'b0, first_i} + (ADDR_W + 1)'(count_i);

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_bit
        assign mask_o[g] = ({1'b0, first_i} <= (ADDR_W + 1)'(g)) &&
                           ((ADDR_W + 1)'(g) < last_excl);
    end
endmodule

// File: rtl/fifo_seg_alloc.sv
module fifo_seg_alloc
    import fsa_pkg::*;
#(
    parameter int          MAXP_W     = 16,
    parameter int          SLOT_W     = 2,
    parameter int          ADDR_W     = 32,
    parameter int          UNIT_BYTES = 512,
    parameter int          NUM_UNITS  = 128,
    parameter logic [31:0] BASE_ADDR  = 32'h0,
    localparam int SIZE_W = MAXP_W + 1 + SLOT_W,
    localparam int UB     = $clog2(UNIT_BYTES),
    localparam int CNT_W  = SIZE_W - UB + 1,
    localparam int IDX_W  = $clog2(NUM_UNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_op_i,
    input  logic [MAXP_W-1:0] req_maxp_i,
    input  logic [SLOT_W-1:0] req_slot_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [SIZE_W-1:0] req_size_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] rsp_addr_o,
    output logic [SIZE_W-1:0] rsp_size_o
);
    typedef struct packed {
        fsa_state_e           st;
        logic [NUM_UNITS-1:0] map;
        logic [IDX_W-1:0]     idx;
        logic [IDX_W:0]       run_start;
        logic [CNT_W-1:0]     run_len;
        logic [CNT_W-1:0]     need;
        logic [SIZE_W-1:0]    bytes;
        logic                 done;
        logic                 fail;
        logic                 was_alloc;
        logic [ADDR_W-1:0]    rsp_addr;
        logic [SIZE_W-1:0]    rsp_size;
    } state_t;

    state_t q, d;

    logic [SIZE_W-1:0]    sz_bytes;
    logic [CNT_W-1:0]     sz_units;
    logic [CNT_W-1:0]     free_units;
    logic [SIZE_W:0]      free_round;
    logic [ADDR_W-1:0]    free_first;
    logic [ADDR_W-1:0]    mask_first;
    logic [CNT_W-1:0]     mask_count;
    logic [NUM_UNITS-1:0] range_mask;
    logic                 accept;

    fsa_sizer #(.MAXP_W(MAXP_W), .SLOT_W(SLOT_W), .UNIT_BYTES(UNIT_BYTES)) u_sizer (
        .maxp_i (req_maxp_i),
        .slot_i (req_slot_i),
        .bytes_o(sz_bytes),
        .units_o(sz_units)
    );

    fsa_rangemask #(.NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mask (
        .first_i(mask_first),
        .count_i(mask_count),
        .mask_o (range_mask)
    );

    assign accept     = req_valid_i && (q.st == ST_IDLE);
    assign free_first = (req_addr_i - ADDR_W'(BASE_ADDR)) >> UB;
    assign free_round = ({1'b0, req_size_i} + (SIZE_W + 1)'(UNIT_BYTES - 1)) >> UB;
    assign free_units = (CNT_W'(free_round) == '0) ? CNT_W'(1) : CNT_W'(free_round);

    always_comb begin
        if (q.st == ST_SCAN) begin
            mask_first = ADDR_W'(q.run_start);
            mask_count = q.need;
        end else begin
            mask_first = free_first;
            mask_count = free_units;
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.fail = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (fsa_op_e'(req_op_i) == OP_FREE) begin
                        d.map       = q.map & ~range_mask;
                        d.done      = 1'b1;
                        d.was_alloc = 1'b0;
                        d.rsp_addr  = '0;
                        d.rsp_size  = '0;
                    end else if (sz_units > CNT_W'(NUM_UNITS)) begin
                        d.done      = 1'b1;
                        d.fail      = 1'b1;
                        d.was_alloc = 1'b1;
                        d.rsp_addr  = '0;
                        d.rsp_size  = '0;
                    end else begin
                        d.st        = ST_SCAN;
                        d.idx       = '0;
                        d.run_start = '0;
                        d.run_len   = '0;
                        d.need      = sz_units;
                        d.bytes     = sz_bytes;
                    end
                end
            end
            ST_SCAN: begin
                if (!q.map[q.idx]) begin
                    d.run_len = q.run_len + 1'b1;
                end else begin
                    d.run_len   = '0;
                    d.run_start = (IDX_W + 1)'(q.idx) + 1'b1;
                end
                if (!q.map[q.idx] && (q.run_len + 1'b1 == q.need)) begin
                    d.st        = ST_IDLE;
                    d.map       = q.map | range_mask;
                    d.done      = 1'b1;
                    d.was_alloc = 1'b1;
                    d.rsp_addr  = ADDR_W'(BASE_ADDR) + (ADDR_W'(q.run_start) << UB);
                    d.rsp_size  = q.bytes;
                end else if (q.idx == IDX_W'(NUM_UNITS - 1)) begin
                    d.st        = ST_IDLE;
                    d.done      = 1'b1;
                    d.fail      = 1'b1;
                    d.was_alloc = 1'b1;
                    d.rsp_addr  = '0;
                    d.rsp_size  = '0;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign busy_o     = (q.st == ST_SCAN);
    assign done_o     = q.done;
    assign fail_o     = q.fail;
    assign rsp_addr_o = q.rsp_addr;
    assign rsp_size_o = q.rsp_size;

    // Completion is a single-cycle pulse (R7)
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // A release accepted in idle completes on the next cycle (R7)
    assert_free_next_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !busy_o && req_op_i) |=> done_o);

    // A failed allocation leaves the occupancy map as it was (R5)
    assert_fail_keeps_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> (q.map == $past(q.map)));

    // A successful allocation returns a unit-aligned address whose unit is now taken (R4)
    assert_alloc_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o && q.was_alloc) |->
        ((rsp_addr_o[UB-1:0] == BASE_ADDR[UB-1:0]) &&
         q.map[IDX_W'((rsp_addr_o - ADDR_W'(BASE_ADDR)) >> UB)]));

    // Requests during a search do not disturb the pending request (R8)
    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_valid_i) |=> (q.need == $past(q.need) && q.bytes == $past(q.bytes)));
endmodule

// File: tb/tb_fifo_seg_alloc.sv
module tb_fifo_seg_alloc;
    localparam int          MAXP_W = 16;
    localparam int          SLOT_W = 2;
    localparam int          ADDR_W = 32;
    localparam int          SIZE_W = MAXP_W + 1 + SLOT_W;
    localparam logic [31:0] BASE   = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid_i = 1'b0;
    logic              req_op_i = 1'b0;
    logic [MAXP_W-1:0] req_maxp_i = '0;
    logic [SLOT_W-1:0] req_slot_i = '0;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic [SIZE_W-1:0] req_size_i = '0;
    logic              busy_o, done_o, fail_o;
    logic [ADDR_W-1:0] rsp_addr_o;
    logic [SIZE_W-1:0] rsp_size_o;

    int checks = 0;
    int errors = 0;
    int lat;
    logic [ADDR_W-1:0] got_addr;
    logic [SIZE_W-1:0] got_size;
    logic              got_fail;

    always #10 clk = ~clk;

    fifo_seg_alloc #(.MAXP_W(MAXP_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
        .req_maxp_i(req_maxp_i), .req_slot_i(req_slot_i), .req_addr_i(req_addr_i),
        .req_size_i(req_size_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .rsp_addr_o(rsp_addr_o), .rsp_size_o(rsp_size_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic op, input int maxp, input int slot, input int addr, input int size);
        @(negedge clk);
        req_op_i    = op;
        req_maxp_i  = MAXP_W'(maxp);
        req_slot_i  = SLOT_W'(slot);
        req_addr_i  = ADDR_W'(addr);
        req_size_i  = SIZE_W'(size);
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        if (!done_o) check("R7 watchdog", 0, 1);
        got_addr = rsp_addr_o;
        got_size = rsp_size_o;
        got_fail = fail_o;
        @(negedge clk);
        check("R7 done one cycle", 64'(done_o), 0);
    endtask

    task automatic alloc_expect(input string req, input int maxp, input int slot,
                                input int unit, input int bytes);
        issue(1'b0, maxp, slot, 0, 0);
        check({req, " fail"}, 64'(got_fail), 0);
        check({req, " addr"}, 64'(got_addr), 64'(BASE + 32'(unit) * 512));
        check({req, " size"}, 64'(got_size), 64'(bytes));
        check("R7 alloc latency", 64'(lat <= 129), 1);
    endtask

    task automatic t_reset;
        check("R9 busy", 64'(busy_o), 0);
        check("R9 done", 64'(done_o), 0);
        check("R9 fail", 64'(fail_o), 0);
    endtask

    task automatic t_sizing;
        alloc_expect("R1 R2 R3 pow2 maxp", 512, 1, 0, 1024);
        alloc_expect("R1 R3 min one unit", 100, 0, 2, 128);
        alloc_expect("R1 R2 R4 six units", 1000, 2, 3, 3072);
    endtask

    task automatic t_free_and_refit;
        issue(1'b1, 0, 0, BASE + 1024, 128);
        check("R6 free done latency", 64'(lat), 1);
        alloc_expect("R6 freed unit reused", 64, 1, 2, 128);
        issue(1'b1, 0, 0, BASE, 1024);
        alloc_expect("R4 skips short hole", 512, 2, 9, 1536);
        alloc_expect("R6 R4 hole filled exactly", 512, 1, 0, 1024);
    endtask

    task automatic t_fail;
        issue(1'b0, 32768, 3, 0, 0);
        check("R5 oversize fail", 64'(got_fail), 1);
        alloc_expect("R5 map kept after oversize", 8, 0, 12, 8);
        alloc_expect("R4 large run", 16384, 1, 13, 32768);
        issue(1'b0, 16384, 1, 0, 0);
        check("R5 fragmentation fail", 64'(got_fail), 1);
        alloc_expect("R5 map kept after scan fail", 8, 0, 77, 8);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        req_op_i = 1'b0; req_maxp_i = 16'd8; req_slot_i = '0; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 busy during search", 64'(busy_o), 1);
        req_op_i = 1'b1; req_addr_i = BASE; req_size_i = SIZE_W'(512); req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        check("R8 search result", 64'(rsp_addr_o), 64'(BASE + 78 * 512));
        @(negedge clk);
        alloc_expect("R8 dropped release left unit 0", 8, 0, 79, 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_sizing;
        t_free_and_refit;
        t_fail;
        t_busy_ignore;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 global watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule